// File: doc/BRIEF.md
# Count/Compare Timer Interrupt

This block keeps a free-running 32-bit tick counter next to a 32-bit match register and raises a level timer interrupt when the counter, stepping forward on an enabled tick, lands on the match value. Each tick input pulse stands for one period of the nominal 100 MHz timebase. The interrupt stays raised until software writes the match register, which both sets a new target and acknowledges the pending interrupt.

Software reaches the block through one write port. A select bit picks the counter or the match register. A read port always shows the live count. The interrupt leaves the block as a single level signal, and it is also placed on bit 7 of an interrupt-line vector, which is the internal line that timer interrupts occupy in the surrounding controller.

Top module: `cc_timer`

## Requirements
- R1: Out of reset the count reads 1, the internal match value is 0, the interrupt is low and every bit of the line vector is 0.
- R2: A cycle with the tick input high and no counter write adds exactly 1 to the count. A cycle with neither a tick nor a counter write leaves the count unchanged.
- R3: A write with select 0 loads the data into the count at the next edge. The write takes priority over a tick in the same cycle.
- R4: The count wraps from 0xFFFFFFFF to 0x00000000 on a tick and never saturates.
- R5: When a tick moves the count onto a value equal to the match register, the interrupt goes high at the same edge that updates the count. This includes a match reached across the wrap.
- R6: Once high, the interrupt stays high through any number of further ticks, idle cycles or counter writes until the match register is written.
- R7: Any write with select 1 loads the match register and drives the interrupt low at the next edge. This holds even when a tick in the same cycle reaches the match value.
- R8: A counter write never raises the interrupt, even when the written value equals the match value. Matching is re-armed, so later ticks that reach the match value do raise it.
- R9: The line vector output carries the interrupt on bit 7 and 0 on every other bit.
- R10: A counter write leaves the match register unchanged. The old match value still triggers on later ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase tick enable, one count step per cycle high |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the counter, 1 selects the match register |
| wr_data_i | input | 32 | Write data |
| count_o | output | 32 | Live count value |
| timer_irq_o | output | 1 | Level timer interrupt |
| irq_lines_o | output | 8 | Interrupt-line vector, with the timer on bit 7 |

## Verification
The bench aims at the interactions between the two write targets and the tick. These are: a counter write landing in the same cycle as a tick, which a design with the wrong priority would resolve to an incremented value; a match-register write racing a matching tick, which a design with set-over-clear priority would leave pending; and a counter write that equals the match value, which a design comparing on level instead of on tick arrival would fire at once. It also drives the count through 0xFFFFFFFF to check the wrap and a match beyond it, and it checks that the interrupt survives ticks past the target and counter rewrites. A design that cleared on mismatch or on a counter write would drop the interrupt early.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  // Write-port target decode; the bit value is part of the register interface.
  typedef enum logic {
    SEL_COUNT   = 1'b0,
    SEL_COMPARE = 1'b1
  } wsel_e;

endpackage

// File: rtl/cc_count_reg.sv
module cc_count_reg #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_q,
  output logic [W-1:0] count_inc
);

  // Modulo-2^W successor; no saturation.
  function automatic logic [W-1:0] advance(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  assign count_inc = advance(count_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= RST_VAL;
    end else if (load_i) begin
      count_q <= load_val_i;
    end else if (step_i) begin
      count_q <= count_inc;
    end
  end

endmodule

// File: rtl/cc_compare_reg.sv
module cc_compare_reg #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cmp_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= RST_VAL;
    end else if (load_i) begin
      cmp_q <= load_val_i;
    end
  end

endmodule

// File: rtl/cc_irq_flag.sv
module cc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);

  // Clear wins over set: an acknowledge is never lost to a racing match.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
    end
  end

endmodule

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int          CNT_W     = 32,
  parameter int          NUM_LINES = 8,
  parameter int          IRQ_LINE  = 7,
  parameter logic [CNT_W-1:0] RST_COUNT   = 1,
  parameter logic [CNT_W-1:0] RST_COMPARE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 wr_en_i,
  input  logic                 wr_sel_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  output logic [CNT_W-1:0]     count_o,
  output logic                 timer_irq_o,
  output logic [NUM_LINES-1:0] irq_lines_o
);

  import cc_timer_pkg::*;

  // Named internal events, brought out for the checker.
  logic             cnt_wr;
  logic             cmp_wr;
  logic             step;
  logic             match_hit;
  logic [CNT_W-1:0] count_inc;
  logic [CNT_W-1:0] cmp_q;

  function automatic logic lands_on(input logic [CNT_W-1:0] nxt,
                                    input logic [CNT_W-1:0] target);
    return nxt == target;
  endfunction

  assign cnt_wr    = wr_en_i && (wsel_e'(wr_sel_i) == SEL_COUNT);
  assign cmp_wr    = wr_en_i && (wsel_e'(wr_sel_i) == SEL_COMPARE);
  assign step      = tick_i && !cnt_wr;
  assign match_hit = step && lands_on(count_inc, cmp_q);

  cc_count_reg #(.W(CNT_W), .RST_VAL(RST_COUNT)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step),
    .load_i     (cnt_wr),
    .load_val_i (wr_data_i),
    .count_q    (count_o),
    .count_inc  (count_inc)
  );

  cc_compare_reg #(.W(CNT_W), .RST_VAL(RST_COMPARE)) u_compare (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cmp_wr),
    .load_val_i (wr_data_i),
    .cmp_q      (cmp_q)
  );

  cc_irq_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (match_hit),
    .clr_i  (cmp_wr),
    .flag_q (timer_irq_o)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    if (g == IRQ_LINE) begin : g_timer
      assign irq_lines_o[g] = timer_irq_o;
    end else begin : g_idle
      assign irq_lines_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int CNT_W     = 32,
  parameter int NUM_LINES = 8,
  parameter int IRQ_LINE  = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_i,
  input logic [CNT_W-1:0]     wr_data_i,
  input logic [CNT_W-1:0]     count_o,
  input logic                 timer_irq_o,
  input logic [NUM_LINES-1:0] irq_lines_o,
  input logic                 cnt_wr,
  input logic                 cmp_wr,
  input logic                 match_hit
);

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_wr) |=> (count_o == $past(count_o) + 1'b1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cnt_wr) |=> $stable(count_o));

  // R3
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_o == $past(wr_data_i)));

  // R5
  match_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_hit && !cmp_wr) |=> timer_irq_o);

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_irq_o && !cmp_wr) |=> timer_irq_o);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !timer_irq_o);

  // R8
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_irq_o) |-> $past(tick_i && !cnt_wr));

  // R9
  line_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines_o) && (irq_lines_o[IRQ_LINE] == timer_irq_o));

endmodule

bind cc_timer cc_timer_chk #(
  .CNT_W     (CNT_W),
  .NUM_LINES (NUM_LINES),
  .IRQ_LINE  (IRQ_LINE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .wr_data_i   (wr_data_i),
  .count_o     (count_o),
  .timer_irq_o (timer_irq_o),
  .irq_lines_o (irq_lines_o),
  .cnt_wr      (cnt_wr),
  .cmp_wr      (cmp_wr),
  .match_hit   (match_hit)
);

// File: tb/cc_timer_bench.sv
module cc_timer_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] count_o;
  logic        timer_irq_o;
  logic [7:0]  irq_lines_o;

  int vectors = 0;
  int miscompares = 0;

  // Bench-side model of the requirements.
  logic [31:0] m_cnt;
  logic [31:0] m_cmp;
  logic        m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_timer u_cc_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .count_o     (count_o),
    .timer_irq_o (timer_irq_o),
    .irq_lines_o (irq_lines_o)
  );

  task automatic check_all(input string req);
    logic [7:0] exp_lines;
    exp_lines = {m_irq, 7'b0};
    vectors++;
    if (count_o !== m_cnt || timer_irq_o !== m_irq || irq_lines_o !== exp_lines) begin
      miscompares++;
      $display("FAIL %s: count=%h irq=%b lines=%b expected count=%h irq=%b lines=%b",
               req, count_o, timer_irq_o, irq_lines_o, m_cnt, m_irq, exp_lines);
    end
  endtask

  // One cycle: drive at the falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic cycle(input logic tk, input logic we, input logic sel,
                       input logic [31:0] d, input string req);
    logic [31:0] nxt;
    tick_i = tk; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    nxt = m_cnt + 32'd1;
    if (we && !sel) begin
      m_cnt = d;
    end else if (tk) begin
      m_cnt = nxt;
      if (!(we && sel) && nxt == m_cmp) m_irq = 1'b1;
    end
    if (we && sel) begin
      m_cmp = d;
      m_irq = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check_all(req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 32'd1; m_cmp = 32'd0; m_irq = 1'b0;
    check_all("R1");
  endtask

  task automatic t_ticks;
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 1'b0, '0, "R2");
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 1'b0, '0, "R2");
    if (count_o !== 32'd6) begin
      miscompares++;
      $display("FAIL R2: count=%h expected=%h", count_o, 32'd6);
    end
    vectors++;
  endtask

  task automatic t_load;
    cycle(1'b0, 1'b1, 1'b0, 32'h0000_0100, "R3");
    cycle(1'b1, 1'b1, 1'b0, 32'h0000_0200, "R3");
  endtask

  task automatic t_match;
    cycle(1'b0, 1'b1, 1'b1, 32'h0000_0205, "R7");
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 1'b0, '0, "R5");
    if (timer_irq_o !== 1'b1 || irq_lines_o !== 8'h80) begin
      miscompares++;
      $display("FAIL R9: irq=%b lines=%h expected irq=1 lines=80", timer_irq_o, irq_lines_o);
    end
    vectors++;
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 1'b0, '0, "R6");
    cycle(1'b0, 1'b0, 1'b0, '0, "R6");
    cycle(1'b0, 1'b1, 1'b0, 32'h0000_0000, "R6");
    cycle(1'b0, 1'b1, 1'b1, 32'h0000_0300, "R7");
  endtask

  task automatic t_rearm;
    cycle(1'b0, 1'b1, 1'b0, 32'h0000_0300, "R8");
    cycle(1'b1, 1'b0, 1'b0, '0, "R8");
    cycle(1'b0, 1'b1, 1'b0, 32'h0000_02FE, "R10");
    cycle(1'b1, 1'b0, 1'b0, '0, "R10");
    cycle(1'b1, 1'b0, 1'b0, '0, "R10");
  endtask

  task automatic t_wrap;
    cycle(1'b0, 1'b1, 1'b1, 32'h0000_0001, "R7");
    cycle(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFE, "R3");
    cycle(1'b1, 1'b0, 1'b0, '0, "R4");
    cycle(1'b1, 1'b0, 1'b0, '0, "R4");
    cycle(1'b1, 1'b0, 1'b0, '0, "R5");
  endtask

  task automatic t_race;
    cycle(1'b0, 1'b1, 1'b1, 32'h0000_0010, "R7");
    cycle(1'b0, 1'b1, 1'b0, 32'h0000_000E, "R3");
    cycle(1'b1, 1'b0, 1'b0, '0, "R2");
    cycle(1'b1, 1'b1, 1'b1, 32'h0000_0010, "R7");
    cycle(1'b1, 1'b0, 1'b0, '0, "R7");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ticks();
    t_load();
    t_match();
    t_rearm();
    t_wrap();
    t_race();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule